// File: doc/BRIEF.md
# Two-Way Green/Red Intersection Light Controller

This block runs a crossing of two roads, north-south and east-west, where each road shows only green or red. At every moment exactly one road has green. A car-presence sensor on each road tells the controller whether traffic is waiting. The controller reviews its choice only once per fixed decision interval, which is 30 seconds by default. At each review it hands green to the other road only when a car is waiting on the road that is red at that moment.

The decision interval comes from a free-running divider clocked by the system clock. Its length is `CLK_HZ * INTERVAL_S` cycles, so a simulation can set small values for both parameters. Each sensor input passes through a two-flop synchronizer before the decision logic uses it. The lamp outputs come straight from the state register, so they change only on the clock edge that ends a decision interval.

Top module: `tl_two_way_ctrl`

## Requirements
- R1: On every cycle exactly one of `ns_green` and `ew_green` is 1. Each red output is the inverse of the green output for the same road.
- R2: A synchronous reset (`rst` = 1) puts north-south on green and clears the interval divider. The first decision edge is the `PERIOD`-th rising edge after the first edge that samples `rst` = 0, where `PERIOD = CLK_HZ * INTERVAL_S`.
- R3: If north-south is green and the synchronized east-west sensor is 1 at a decision edge, east-west becomes green on that edge. The north-south sensor has no effect on this.
- R4: If north-south is green and the synchronized east-west sensor is 0 at a decision edge, north-south stays green. This holds for either value of the north-south sensor.
- R5: If east-west is green and the synchronized north-south sensor is 1 at a decision edge, north-south becomes green on that edge. The east-west sensor has no effect on this.
- R6: If east-west is green and the synchronized north-south sensor is 0 at a decision edge, east-west stays green. This holds for either value of the east-west sensor.
- R7: Between decision edges the lamp outputs do not change, whatever the sensors do.
- R8: Decision edges occur every `PERIOD` cycles, and two consecutive cycles are never both decision cycles.
- R9: Each sensor reaches the decision logic through a two-flop synchronizer. A sensor value first applied between the second-last and the last rising edge before a decision edge has no effect on that decision. The decision after it does see the value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| ns_car | input | 1 | North-south car sensor, asynchronous, 1 = car waiting |
| ew_car | input | 1 | East-west car sensor, asynchronous, 1 = car waiting |
| ns_green | output | 1 | North-south green lamp |
| ew_green | output | 1 | East-west green lamp |
| ns_red | output | 1 | North-south red lamp |
| ew_red | output | 1 | East-west red lamp |

## Verification
Several behaviours are checked on every cycle by the assertions:
- the one-green rule;
- the red/green inversion;
- the reset state;
- the lamps holding steady away from a tick;
- tick spacing;
- each of the four transition rules, stated against the synchronized sensor values.

Some behaviours only the bench scenarios can show:
- The exact edge on which the first and later decisions land, counted from reset release.
- That every row of the transition table is reached from the raw, unsynchronized pins.
- That a sensor change arriving late, inside the two-edge synchronizer window, is deferred to the next interval.

// File: rtl/tl_pkg.sv
package tl_pkg;
  typedef enum logic {
    PH_NS = 1'b0,
    PH_EW = 1'b1
  } phase_t;
endpackage

// File: rtl/tl_interval_timer.sv
module tl_interval_timer #(
  parameter int PERIOD = 1500000000
) (
  input  logic clk,
  input  logic rst,
  output logic tick
);
  localparam int CW = (PERIOD > 1) ? $clog2(PERIOD) : 1;
  localparam logic [CW-1:0] LAST = CW'(PERIOD - 1);

  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)
      cnt_q <= '0;
    else if (cnt_q == LAST)
      cnt_q <= '0;
    else
      cnt_q <= cnt_q + CW'(1);
  end

  assign tick = (cnt_q == LAST);
endmodule

// File: rtl/tl_sync.sv
module tl_sync #(
  parameter int W      = 2,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg_q [STAGES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < STAGES; i++) stg_q[i] <= '0;
    end else begin
      stg_q[0] <= d;
      for (int i = 1; i < STAGES; i++) stg_q[i] <= stg_q[i-1];
    end
  end

  assign q = stg_q[STAGES-1];
endmodule

// File: rtl/tl_phase_fsm.sv
module tl_phase_fsm
  import tl_pkg::*;
(
  input  logic   clk,
  input  logic   rst,
  input  logic   tick,
  input  logic   ns_car_s,
  input  logic   ew_car_s,
  output phase_t phase
);
  phase_t phase_q, phase_d;

  always_comb begin
    phase_d = phase_q;
    if (tick) begin
      unique case (phase_q)
        PH_NS:   if (ew_car_s) phase_d = PH_EW;
        PH_EW:   if (ns_car_s) phase_d = PH_NS;
        default: phase_d = PH_NS;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) phase_q <= PH_NS;
    else     phase_q <= phase_d;
  end

  assign phase = phase_q;
endmodule

// File: rtl/tl_two_way_ctrl.sv
module tl_two_way_ctrl
  import tl_pkg::*;
#(
  parameter int CLK_HZ     = 50000000,
  parameter int INTERVAL_S = 30,
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ns_car,
  input  logic ew_car,
  output logic ns_green,
  output logic ew_green,
  output logic ns_red,
  output logic ew_red
);
  localparam int PERIOD = CLK_HZ * INTERVAL_S;

  logic       tick;
  logic [1:0] car_s;
  logic       ns_car_s, ew_car_s;
  phase_t     phase;

  tl_interval_timer #(.PERIOD(PERIOD)) u_timer (
    .clk  (clk),
    .rst  (rst),
    .tick (tick)
  );

  tl_sync #(.W(2), .STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rst (rst),
    .d   ({ns_car, ew_car}),
    .q   (car_s)
  );

  assign ns_car_s = car_s[1];
  assign ew_car_s = car_s[0];

  tl_phase_fsm u_fsm (
    .clk      (clk),
    .rst      (rst),
    .tick     (tick),
    .ns_car_s (ns_car_s),
    .ew_car_s (ew_car_s),
    .phase    (phase)
  );

  assign ns_green = (phase == PH_NS);
  assign ew_green = (phase == PH_EW);
  assign ns_red   = ~ns_green;
  assign ew_red   = ~ew_green;
endmodule

// File: rtl/tl_two_way_chk.sv
module tl_two_way_chk (
  input logic clk,
  input logic rst,
  input logic tick,
  input logic ns_car_s,
  input logic ew_car_s,
  input logic ns_green,
  input logic ew_green,
  input logic ns_red,
  input logic ew_red
);
  p_one_green_r1: assert property (@(posedge clk) disable iff (rst)
    $countones({ns_green, ew_green}) == 1);

  p_red_inverse_r1: assert property (@(posedge clk) disable iff (rst)
    (ns_red != ns_green) && (ew_red != ew_green));

  p_reset_ns_r2: assert property (@(posedge clk)
    rst |=> (ns_green && !ew_green));

  p_ns_to_ew_r3: assert property (@(posedge clk) disable iff (rst)
    (tick && ns_green && ew_car_s) |=> ew_green);

  p_ns_stay_r4: assert property (@(posedge clk) disable iff (rst)
    (tick && ns_green && !ew_car_s) |=> ns_green);

  p_ew_to_ns_r5: assert property (@(posedge clk) disable iff (rst)
    (tick && ew_green && ns_car_s) |=> ns_green);

  p_ew_stay_r6: assert property (@(posedge clk) disable iff (rst)
    (tick && ew_green && !ns_car_s) |=> ew_green);

  p_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !tick |=> ($stable(ns_green) && $stable(ew_green)));

  p_tick_spacing_r8: assert property (@(posedge clk) disable iff (rst)
    tick |=> !tick);
endmodule

bind tl_two_way_ctrl tl_two_way_chk u_chk (
  .clk      (clk),
  .rst      (rst),
  .tick     (tick),
  .ns_car_s (ns_car_s),
  .ew_car_s (ew_car_s),
  .ns_green (ns_green),
  .ew_green (ew_green),
  .ns_red   (ns_red),
  .ew_red   (ew_red)
);

// File: tb/tl_two_way_ctrl_test.sv
`timescale 1ns/1ps
module tl_two_way_ctrl_test;
  localparam int HZ  = 2;
  localparam int SEC = 5;
  localparam int P   = HZ * SEC;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ns_car = 1'b0;
  logic ew_car = 1'b0;
  logic ns_green, ew_green, ns_red, ew_red;

  int checks = 0;
  int errors = 0;
  bit finished = 0;
  bit exp_ew;

  always #2 clk = ~clk;

  tl_two_way_ctrl #(.CLK_HZ(HZ), .INTERVAL_S(SEC)) uut (
    .clk(clk), .rst(rst), .ns_car(ns_car), .ew_car(ew_car),
    .ns_green(ns_green), .ew_green(ew_green), .ns_red(ns_red), .ew_red(ew_red)
  );

  task automatic check_lamps(input bit want_ew, input string tag);
    checks++;
    if (ns_green !== !want_ew || ew_green !== want_ew ||
        ns_red !== want_ew || ew_red !== !want_ew) begin
      errors++;
      $display("FAIL %s: ns_g=%b ew_g=%b ns_r=%b ew_r=%b expected ns_g=%b ew_g=%b ns_r=%b ew_r=%b",
               tag, ns_green, ew_green, ns_red, ew_red, !want_ew, want_ew, want_ew, !want_ew);
    end
  endtask

  // Reset for a few cycles; release at a negedge so the next posedge is edge 1.
  task automatic do_reset(input string tag);
    @(negedge clk);
    rst = 1'b1;
    ns_car = 1'b0;
    ew_car = 1'b0;
    repeat (3) @(negedge clk);
    check_lamps(1'b0, {tag, " R2 reset NS green"});
    rst = 1'b0;
    exp_ew = 1'b0;
  endtask

  // One full interval with steady sensor values; lamps must hold until edge P.
  task automatic run_interval(input logic ns_in, input logic ew_in, input string tag);
    bit nxt;
    ns_car = ns_in;
    ew_car = ew_in;
    nxt = exp_ew ? !ns_in : ew_in;
    for (int i = 1; i <= P; i++) begin
      @(negedge clk);
      if (i < P) check_lamps(exp_ew, {tag, " R7 hold before decision"});
      else       check_lamps(nxt, tag);
    end
    exp_ew = nxt;
  endtask

  // Sensors toggle during the interval, then settle to "no car".
  task automatic toggle_interval(input string tag);
    for (int i = 1; i <= P; i++) begin
      @(negedge clk);
      if (i < P) check_lamps(exp_ew, {tag, " R7 no change while sensors toggle"});
      else       check_lamps(exp_ew, {tag, " R7 settled no car keeps phase"});
      if (i < P - 4) begin
        ns_car = ~ns_car;
        ew_car = ~ew_car;
      end else begin
        ns_car = 1'b0;
        ew_car = 1'b0;
      end
    end
  endtask

  // East-west car appears inside the synchronizer window of the decision.
  task automatic late_sensor(input string tag);
    ns_car = 1'b0;
    ew_car = 1'b0;
    for (int i = 1; i <= P; i++) begin
      @(negedge clk);
      check_lamps(1'b0, {tag, " R9 late sensor not yet seen"});
      if (i == P - 2) ew_car = 1'b1;
    end
    exp_ew = 1'b0;
    run_interval(1'b0, 1'b1, {tag, " R9 late sensor seen next decision"});
  endtask

  initial begin
    do_reset("init");
    run_interval(1'b0, 1'b0, "R4 NS row 00 stays NS; R8 first decision at edge P");
    run_interval(1'b1, 1'b0, "R4 NS row ns=1 ew=0 stays NS");
    run_interval(1'b0, 1'b1, "R3 NS row ns=0 ew=1 goes EW");
    run_interval(1'b0, 1'b0, "R6 EW row 00 stays EW");
    run_interval(1'b0, 1'b1, "R6 EW row ns=0 ew=1 stays EW");
    run_interval(1'b1, 1'b1, "R5 EW row ns=1 ew=1 goes NS");
    run_interval(1'b1, 1'b1, "R3 NS row ns=1 ew=1 goes EW");
    run_interval(1'b1, 1'b0, "R5 EW row ns=1 ew=0 goes NS");
    toggle_interval("R7 toggle");
    late_sensor("R9 window");
    do_reset("mid R2");
    run_interval(1'b0, 1'b1, "R2 first decision after mid reset at edge P");
    finished = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    #(4 * 20000);
    if (!finished) begin
      checks++;
      errors++;
      $display("FAIL watchdog: run did not complete, actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule